// File: doc/BRIEF.md
# Serial Flash Top-Anchored Write Protection Gate

This block sits between the command decoder of a serial flash device and its array sequencer. It keeps a three-bit protect level that software loads through a status-register write strobe. For every program or erase request, it decides in one registered cycle whether the request may proceed. The array holds 64 sectors. The protected region is always a power-of-two run of sectors that ends at the topmost sector, and it grows as the protect level rises.

A request carries an operation type and a byte address. Page program and sector erase requests take their sector index from the upper address bits and are refused if that sector lies inside the protected range. Bulk erase ignores the address and is refused unless the protect level is zero. The block also presents, as a combinational output, the lowest protected sector and a flag that says whether any protection is active. These outputs let a neighbouring status path show the protected range.

Top module: `fprot_gate`

## Requirements
- R1: After reset, the protect level is 000, no sector is protected (`prot_any`=0, `prot_floor`=64), and neither `req_grant` nor `req_deny` is high.
- R2: The protect level changes only in the cycle after `lvl_we` is high, taking the value of `lvl_wdata`. Without that strobe it holds its value, and the strobe has no other effect.
- R3: The lowest protected sector `prot_floor` is 64 for level 000 and 0 for level 111. For levels 1 to 6 it is 64 − 2^(level−1), giving 63, 62, 60, 56, 48 and 32. `prot_any` is 1 exactly when the level is nonzero.
- R4: The sector index of a request is address bits [21:16] of the 22-bit `req_addr`.
- R5: A page program (`req_op`=2'b00) or sector erase (`req_op`=2'b01) is denied when its sector index is at or above `prot_floor`, and granted otherwise.
- R6: A bulk erase (`req_op`=2'b10) is granted only when the protect level is 000, whatever the address. It is denied otherwise. Code 2'b11 is reserved and always denied.
- R7: For each cycle with `req_valid` high, exactly one of `req_grant` and `req_deny` is high for one cycle on the next clock edge. Both are low in any cycle that does not follow a request.
- R8: A request uses the protect level in force in the cycle it is sampled. A `lvl_we` in that same cycle affects only later requests, including a request that follows back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lvl_we | input | 1 | Load strobe for the protect level |
| lvl_wdata | input | 3 | New protect level |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 00 page program, 01 sector erase, 10 bulk erase, 11 reserved |
| req_addr | input | 22 | Target byte address |
| req_grant | output | 1 | One-cycle grant response |
| req_deny | output | 1 | One-cycle deny response |
| prot_any | output | 1 | Some sector is protected |
| prot_floor | output | 7 | Lowest protected sector, 64 when none |

## Verification
A level write becomes visible on `prot_floor` and `prot_any` one clock after the strobe, because one register lies on that path. A request's grant or deny appears one clock after its strobe, and it uses the level as it stood before any write in the same cycle. The bench drives inputs on the falling edge. It samples `prot_floor` and the response outputs after the following rising edge. Back-to-back request checks sample both responses, one per cycle, in the order the requests were issued.

// File: rtl/fprot_pkg.sv
package fprot_pkg;
  localparam int LVL_W    = 3;
  localparam int SEC_W    = 6;
  localparam int NUM_SEC  = 1 << SEC_W;
  localparam int FLOOR_W  = SEC_W + 1;
  localparam int ADDR_W   = 22;
  localparam int SEC_LSB  = ADDR_W - SEC_W;

  typedef enum logic [1:0] {
    OP_PAGE_PROG = 2'b00,
    OP_SEC_ERASE = 2'b01,
    OP_BULK      = 2'b10,
    OP_RSVD      = 2'b11
  } op_e;

  // Lowest protected sector for a protect level; NUM_SEC means none.
  function automatic logic [FLOOR_W-1:0] level_floor(input logic [LVL_W-1:0] lvl);
    int span;
    if (lvl == '0) return FLOOR_W'(NUM_SEC);
    if (lvl == '1) return '0;
    span = 1 << (int'(lvl) - 1);
    return FLOOR_W'(NUM_SEC - span);
  endfunction
endpackage

// File: rtl/fprot_level_reg.sv
module fprot_level_reg
  import fprot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [LVL_W-1:0] wdata,
  output logic [LVL_W-1:0] level
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  level <= '0;
    else if (we) level <= wdata;
  end

  // R2: level holds unless strobed
  a_r2_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(level));
  a_r2_level_loads: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> level == $past(wdata));
endmodule

// File: rtl/fprot_range.sv
module fprot_range
  import fprot_pkg::*;
(
  input  logic [LVL_W-1:0]   level,
  output logic [FLOOR_W-1:0] floor_sec,
  output logic               any_prot,
  output logic               bulk_ok
);
  assign floor_sec = level_floor(level);
  assign any_prot  = (level != '0);
  assign bulk_ok   = (level == '0);

  // R3: floor and any flag agree
  always_comb begin
    a_r3_floor_consistent: assert (any_prot == (floor_sec < FLOOR_W'(NUM_SEC)));
  end
endmodule

// File: rtl/fprot_decide.sv
module fprot_decide
  import fprot_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid,
  input  logic [1:0]         op,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [FLOOR_W-1:0] floor_sec,
  input  logic               bulk_ok,
  output logic               grant,
  output logic               deny
);
  logic [SEC_W-1:0] sec_idx;
  logic             sec_hit;
  logic             allow;

  assign sec_idx = addr[ADDR_W-1:SEC_LSB];
  assign sec_hit = ({1'b0, sec_idx} >= floor_sec);

  always_comb begin
    unique case (op_e'(op))
      OP_PAGE_PROG, OP_SEC_ERASE: allow = !sec_hit;
      OP_BULK:                    allow = bulk_ok;
      default:                    allow = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant <= 1'b0;
      deny  <= 1'b0;
    end else begin
      grant <= valid & allow;
      deny  <= valid & !allow;
    end
  end

  // R7: exactly one response per request
  a_r7_one_response: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> (grant ^ deny));
  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> !grant && !deny);
  // R6: bulk erase never granted while protected
  a_r6_bulk_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op == 2'b10 && !bulk_ok) |=> deny);
  // R5: reserved op and protected sector never granted
  a_r5_sector_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op != 2'b10 && sec_hit) |=> !grant);
endmodule

// File: rtl/fprot_gate.sv
module fprot_gate
  import fprot_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lvl_we,
  input  logic [2:0]  lvl_wdata,
  input  logic        req_valid,
  input  logic [1:0]  req_op,
  input  logic [21:0] req_addr,
  output logic        req_grant,
  output logic        req_deny,
  output logic        prot_any,
  output logic [6:0]  prot_floor
);
  logic [LVL_W-1:0]   level;
  logic [FLOOR_W-1:0] floor_sec;
  logic               bulk_ok;

  fprot_level_reg u_lvl (
    .clk(clk), .rst_n(rst_n), .we(lvl_we), .wdata(lvl_wdata), .level(level)
  );

  fprot_range u_rng (
    .level(level), .floor_sec(floor_sec), .any_prot(prot_any), .bulk_ok(bulk_ok)
  );

  fprot_decide u_dec (
    .clk(clk), .rst_n(rst_n), .valid(req_valid), .op(req_op), .addr(req_addr),
    .floor_sec(floor_sec), .bulk_ok(bulk_ok), .grant(req_grant), .deny(req_deny)
  );

  assign prot_floor = floor_sec;

  // R1: responses idle right after reset release
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (req_grant || req_deny) |-> $past(req_valid));
endmodule

// File: tb/test_fprot_gate.sv
module test_fprot_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lvl_we = 1'b0;
  logic [2:0]  lvl_wdata = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = '0;
  logic [21:0] req_addr = '0;
  logic        req_grant, req_deny, prot_any;
  logic [6:0]  prot_floor;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fprot_gate i_fprot_gate (.*);

  function automatic int exp_floor(int lvl);
    if (lvl == 0) return 64;
    if (lvl == 7) return 0;
    return 64 - (2 ** (lvl - 1));
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_level(int lvl);
    @(negedge clk);
    lvl_we = 1; lvl_wdata = 3'(lvl);
    @(negedge clk);
    lvl_we = 0;
  endtask

  // drive one request; returns {grant,deny} sampled after next edge
  task automatic request(int op, int sec, int low, output logic [1:0] gd);
    @(negedge clk);
    req_valid = 1; req_op = 2'(op); req_addr = {6'(sec), 16'(low)};
    @(negedge clk);
    req_valid = 0;
    gd = {req_grant, req_deny};
  endtask

  task automatic t_reset;
    check("R1 floor", prot_floor, 64);
    check("R1 any", prot_any, 0);
    check("R1 grant", req_grant, 0);
    check("R1 deny", req_deny, 0);
  endtask

  task automatic t_levels;
    for (int l = 0; l < 8; l++) begin
      set_level(l);
      check("R3 floor", prot_floor, exp_floor(l));
      check("R3 any", prot_any, l != 0);
    end
  endtask

  task automatic t_hold;
    set_level(4);
    @(negedge clk); lvl_wdata = 3'd7;
    repeat (3) @(negedge clk);
    check("R2 hold floor", prot_floor, 56);
  endtask

  task automatic t_sectors;
    logic [1:0] gd;
    for (int l = 0; l < 8; l++) begin
      set_level(l);
      for (int s = 0; s < 64; s += 7) begin
        request(s & 1, s, 16'hBEEF, gd);
        check("R5 sector", gd, (s >= exp_floor(l)) ? 2'b01 : 2'b10);
      end
      request(0, 63, 16'hFFFF, gd);
      check("R5 top", gd, (l == 0) ? 2'b10 : 2'b01);
      request(1, 0, 0, gd);
      check("R5 bottom", gd, (l == 7) ? 2'b01 : 2'b10);
    end
    set_level(3);
    request(0, 59, 16'hFFFF, gd); check("R4 below edge", gd, 2'b10);
    request(0, 60, 16'h0000, gd); check("R4 at edge", gd, 2'b01);
  endtask

  task automatic t_bulk;
    logic [1:0] gd;
    for (int l = 0; l < 8; l++) begin
      set_level(l);
      request(2, 0, 0, gd);
      check("R6 bulk", gd, (l == 0) ? 2'b10 : 2'b01);
      request(3, 0, 0, gd);
      check("R6 reserved", gd, 2'b01);
    end
  endtask

  task automatic t_b2b;
    set_level(0);
    @(negedge clk);
    req_valid = 1; req_op = 2'd2; req_addr = '0; lvl_we = 1; lvl_wdata = 3'd1;
    @(negedge clk);
    lvl_we = 0;
    check("R8 first grant", req_grant, 1);
    check("R7 first deny", req_deny, 0);
    req_op = 2'd0; req_addr = {6'd63, 16'd0};
    @(negedge clk);
    req_valid = 0;
    check("R8 second deny", req_deny, 1);
    check("R7 second grant", req_grant, 0);
    @(negedge clk);
    check("R7 quiet", {req_grant, req_deny}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_levels();
    t_hold();
    t_sectors();
    t_bulk();
    t_b2b();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule